// File: doc/BRIEF.md
# Branch Target Buffer with Next-PC Selection

This block is the prediction step of an instruction fetch stage. It keeps the fetch program counter and looks it up every cycle in a small fully associative table. Each table entry holds a full instruction address, the target address last seen for that instruction and a one-bit direction predictor. A hit with a taken prediction sends fetch to the stored target. A hit with a not-taken prediction, or a miss, sends it to the sequential address four bytes on. A miss means the instruction is treated as a non-branch.

Once a branch or jump has been resolved further down the pipeline, it is reported on the update port. A known instruction has its target and predictor rewritten. An unknown one is installed, taking the least recently used slot when the table is full. Jumps always predict taken. The fetch unit can also load the PC directly with a steer request, for example after a misprediction is recovered elsewhere. When no steer is given, the PC follows the predicted next PC on each enabled cycle.

Top module: `btb_nextpc`

## Requirements
- R1: After reset the fetch PC is the parameter RESET_PC (600 by default) and no lookup hits, so every entry is empty.
- R2: When the current PC matches no valid entry, `look_hit` is 0 and `next_pc` is the PC plus 4.
- R3: On a hit, `look_target` is the stored target. `next_pc` is that target when the stored predictor is 1 (taken) and the PC plus 4 when it is 0 (not taken).
- R4: An update for an address not in the table installs it, whether the outcome was taken or not taken. The new predictor equals the outcome (1 = taken, 0 = not taken) and the new target equals the reported target.
- R5: An update for an address already in the table overwrites that entry's predictor with the outcome and its target with the reported target. No second entry is created for that address.
- R6: An update flagged as a jump is stored with predictor 1, whatever the outcome input says.
- R7: When all entries are valid, an install replaces the least recently used entry. A lookup hit and an update both make their entry the most recently used.
- R8: When an update and a lookup of the same address fall in the same cycle, the lookup reports the table contents from before that update. The new contents are visible from the next cycle.
- R9: A steer request loads its address into the PC at the next edge. Otherwise the PC takes `next_pc` when `fetch_en` is 1 and holds when it is 0. Steer takes priority.
- R10: The table holds ENTRIES (16 by default) distinct addresses at once. All of them hit after they have been installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_en | input | 1 | Advance the PC to `next_pc` this cycle |
| steer_valid | input | 1 | Load `steer_pc` into the PC |
| steer_pc | input | ADDR_W | Address to load on steer |
| upd_valid | input | 1 | A resolved branch or jump is reported |
| upd_pc | input | ADDR_W | Address of the resolved instruction |
| upd_target | input | ADDR_W | Its resolved target address |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_jump | input | 1 | The resolved instruction is an unconditional jump |
| fetch_pc | output | ADDR_W | Current fetch PC, the lookup address |
| look_hit | output | 1 | The fetch PC is in the table |
| look_taken | output | 1 | Stored predictor of the hit entry (0 on a miss) |
| look_target | output | ADDR_W | Stored target of the hit entry (0 on a miss) |
| next_pc | output | ADDR_W | Predicted next fetch PC |

## Verification
The assertions rely on one assumption: the update port never reports an address that is already held in two entries. The one-hot match check and the install-after-update checks depend on this, and it holds as long as every update goes through this block's own hit search. The assertions also expect the recency ranks to stay a permutation, which the reset values set up and every touch preserves. The stimulus uses only word-aligned addresses and deasserts `fetch_en` while it sets up the table. This keeps the PC parked on an address that is not in the table, so no lookup hit reorders recency except where a scenario means it to. Each scenario starts from a fresh reset whenever its expected victims depend on the fill order.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Byte distance between sequential instructions.
  localparam int unsigned INSN_BYTES = 4;

  // Where the predicted next PC comes from.
  typedef enum logic {
    NPC_SEQ = 1'b0,
    NPC_TGT = 1'b1
  } npc_src_e;
endpackage

// File: rtl/btb_cam.sv
// Fully associative address match: one comparator per entry plus an encoder.
module btb_cam #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    key,
  input  logic [ENTRIES-1:0]   valid,
  input  logic [ADDR_W-1:0]    tags [ENTRIES],
  output logic                 hit,
  output logic [IDX_W-1:0]     idx
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx = idx | IDX_W'(i);
    end
  end

  assign hit = |match;

  // R5: an address never occupies two entries.
  a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/btb_lru.sv
// True LRU by age rank: 0 = most recent, ENTRIES-1 = victim.
module btb_lru #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned W      = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          look_touch,
  input  logic [W-1:0]  look_idx,
  input  logic          upd_en,
  input  logic          upd_hit,
  input  logic [W-1:0]  upd_hit_idx,
  output logic [W-1:0]  wr_idx
);
  localparam logic [W-1:0] OLDEST = W'(ENTRIES - 1);

  logic [W-1:0] age_q [ENTRIES];
  logic [W-1:0] age_a [ENTRIES];
  logic [W-1:0] age_d [ENTRIES];
  logic [W-1:0] victim;
  logic         age_en;

  // Next state: lookup touch first, then the update touch on top of it.
  always_comb begin
    age_a = age_q;
    if (look_touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (W'(i) == look_idx)                 age_a[i] = '0;
        else if (age_q[i] < age_q[look_idx])   age_a[i] = age_q[i] + 1'b1;
      end
    end
    victim = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (age_a[i] == OLDEST) victim = W'(i);
    end
    wr_idx = upd_hit ? upd_hit_idx : victim;
    age_d  = age_a;
    if (upd_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (W'(i) == wr_idx)                   age_d[i] = '0;
        else if (age_a[i] < age_a[wr_idx])     age_d[i] = age_a[i] + 1'b1;
      end
    end
  end

  assign age_en = look_touch || upd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= W'(i);
    end else if (age_en) begin
      age_q <= age_d;
    end
  end

  // R7: ranks stay a permutation, so exactly one entry is the victim.
  logic [ENTRIES-1:0] is_oldest;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign is_oldest[g] = (age_q[g] == OLDEST);
  end
  a_r7_one_victim: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_oldest) == 1);
endmodule

// File: rtl/btb_nextpc.sv
module btb_nextpc #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ENTRIES  = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = ADDR_W'(600),
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic              steer_valid,
  input  logic [ADDR_W-1:0] steer_pc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken,
  input  logic              upd_jump,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              look_hit,
  output logic              look_taken,
  output logic [ADDR_W-1:0] look_target,
  output logic [ADDR_W-1:0] next_pc
);
  import btb_pkg::*;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // Table storage.
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  logic [ENTRIES-1:0] pred_q;
  logic [ADDR_W-1:0]  pc_q, pc_d;
  logic               pc_en;

  logic               l_hit, u_hit;
  logic [IDX_W-1:0]   l_idx, u_idx, wr_idx;
  npc_src_e           npc_src;
  logic               new_pred;

  btb_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_look_cam (
    .clk(clk), .rst_n(rst_int_n), .key(pc_q), .valid(valid_q),
    .tags(tag_q), .hit(l_hit), .idx(l_idx));

  btb_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_upd_cam (
    .clk(clk), .rst_n(rst_int_n), .key(upd_pc), .valid(valid_q),
    .tags(tag_q), .hit(u_hit), .idx(u_idx));

  btb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_int_n),
    .look_touch(l_hit), .look_idx(l_idx),
    .upd_en(upd_valid), .upd_hit(u_hit), .upd_hit_idx(u_idx),
    .wr_idx(wr_idx));

  // Lookup and next-PC selection (reads the table as it stood before any
  // same-cycle update).
  always_comb begin
    look_hit    = l_hit;
    look_taken  = l_hit && pred_q[l_idx];
    look_target = l_hit ? tgt_q[l_idx] : '0;
    npc_src     = look_taken ? NPC_TGT : NPC_SEQ;
    next_pc     = (npc_src == NPC_TGT) ? look_target
                                       : pc_q + ADDR_W'(INSN_BYTES);
  end

  assign fetch_pc = pc_q;

  // PC next state.
  always_comb begin
    pc_en = steer_valid || fetch_en;
    pc_d  = steer_valid ? steer_pc : next_pc;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  pc_q <= RESET_PC;
    else if (pc_en)  pc_q <= pc_d;
  end

  // Table next state.
  assign new_pred = upd_jump || upd_taken;

  always_comb begin
    valid_d = valid_q;
    if (upd_valid) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) valid_q <= '0;
    else if (upd_valid) valid_q <= valid_d;
  end

  // Payload fields carry no reset; the valid bit guards them.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic wr_en;
    assign wr_en = upd_valid && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        tag_q[g]  <= upd_pc;
        tgt_q[g]  <= upd_target;
        pred_q[g] <= new_pred;
      end
    end
  end

  // R2: a miss with fetch enabled steps the PC by one instruction.
  a_r2_miss_sequential: assert property (@(posedge clk) disable iff (!rst_int_n)
    fetch_en && !steer_valid && !look_hit |=> fetch_pc == $past(fetch_pc) + ADDR_W'(4));

  // R6: a jump, once reported, is found with taken prediction and its target.
  a_r6_jump_taken: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_valid && upd_jump |=>
      (fetch_pc != $past(upd_pc)) ||
      (look_hit && look_taken && look_target == $past(upd_target)));

  // R4: a branch, once reported, is found with its outcome as prediction.
  a_r4_outcome_kept: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_valid && !upd_jump |=>
      (fetch_pc != $past(upd_pc)) ||
      (look_hit && look_taken == $past(upd_taken)));
endmodule

// File: tb/btb_nextpc_test.sv
module btb_nextpc_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_en = 1'b0;
  logic          steer_valid = 1'b0;
  logic [AW-1:0] steer_pc = '0;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic [AW-1:0] upd_target = '0;
  logic          upd_taken = 1'b0;
  logic          upd_jump = 1'b0;
  logic [AW-1:0] fetch_pc, look_target, next_pc;
  logic          look_hit, look_taken;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  btb_nextpc uut (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en),
    .steer_valid(steer_valid), .steer_pc(steer_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_taken(upd_taken), .upd_jump(upd_jump),
    .fetch_pc(fetch_pc), .look_hit(look_hit), .look_taken(look_taken),
    .look_target(look_target), .next_pc(next_pc));

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic steer(logic [AW-1:0] a);
    @(negedge clk);
    steer_valid = 1'b1; steer_pc = a;
    @(negedge clk);
    steer_valid = 1'b0;
    #1;
  endtask

  task automatic install(logic [AW-1:0] a, logic [AW-1:0] t, logic tk, logic jp);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = a; upd_target = t; upd_taken = tk; upd_jump = jp;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1 pc", fetch_pc, 600);
    check("R1 hit", AW'(look_hit), 0);
    check("R2 next", next_pc, 604);
  endtask

  task automatic t_miss_advance();
    @(negedge clk); fetch_en = 1'b1;
    @(negedge clk); fetch_en = 1'b0; #1;
    check("R9 advance", fetch_pc, 604);
    @(negedge clk); #1;
    check("R9 hold", fetch_pc, 604);
  endtask

  task automatic t_not_taken_install();
    install(608, 700, 1'b0, 1'b0);
    steer(608);
    check("R4 hit", AW'(look_hit), 1);
    check("R4 pred0", AW'(look_taken), 0);
    check("R4 target", look_target, 700);
    check("R3 seq", next_pc, 612);
  endtask

  task automatic t_refresh_taken();
    install(608, 720, 1'b1, 1'b0);
    #1;
    check("R5 pred1", AW'(look_taken), 1);
    check("R5 target", look_target, 720);
    check("R3 to target", next_pc, 720);
    @(negedge clk); fetch_en = 1'b1;
    @(negedge clk); fetch_en = 1'b0; #1;
    check("R9 follow", fetch_pc, 720);
    // refresh back to not taken: still a single entry, prediction follows
    install(608, 724, 1'b0, 1'b0);
    steer(608);
    check("R5 back0", AW'(look_taken), 0);
    check("R5 tgt2", look_target, 724);
  endtask

  task automatic t_jump();
    install(640, 900, 1'b0, 1'b1);
    steer(640);
    check("R6 taken", AW'(look_taken), 1);
    check("R6 next", next_pc, 900);
    install(644, 904, 1'b1, 1'b0);
    steer(644);
    check("R4 taken new", AW'(look_taken), 1);
  endtask

  task automatic t_same_cycle();
    steer(660);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 660; upd_target = 880; upd_taken = 1'b1; upd_jump = 1'b0;
    #1;
    check("R8 old miss", AW'(look_hit), 0);
    check("R8 old next", next_pc, 664);
    @(negedge clk);
    upd_valid = 1'b0; #1;
    check("R8 new hit", AW'(look_hit), 1);
    check("R8 new next", next_pc, 880);
  endtask

  task automatic t_capacity();
    do_reset();
    for (int i = 0; i < 16; i++) install(AW'(800 + 8 * i), AW'(2000 + 8 * i), 1'b1, 1'b0);
    for (int i = 0; i < 16; i++) begin
      steer(AW'(800 + 8 * i));
      check("R10 hit", AW'(look_hit), 1);
      check("R10 tgt", look_target, AW'(2000 + 8 * i));
    end
  endtask

  task automatic t_lru();
    do_reset();
    for (int i = 0; i < 16; i++) install(AW'(800 + 8 * i), AW'(2000 + 8 * i), 1'b1, 1'b0);
    steer(800);                // lookup hit makes entry 800 most recent
    check("R7 touch", AW'(look_hit), 1);
    steer(600);
    install(1200, 3000, 1'b1, 1'b0);   // victim must be 808
    steer(808);
    check("R7 evicted", AW'(look_hit), 0);
    steer(1200);
    check("R7 new", look_target, 3000);
    steer(800);
    check("R7 kept", AW'(look_hit), 1);
    steer(600);
    install(816, 4000, 1'b1, 1'b0);    // refresh via update makes 816 recent
    install(1300, 3100, 1'b0, 1'b0);   // victim must be 824
    steer(824);
    check("R7 evict2", AW'(look_hit), 0);
    steer(816);
    check("R7 upd kept", look_target, 4000);
  endtask

  initial begin
    t_reset();
    t_miss_advance();
    t_not_taken_install();
    t_refresh_taken();
    t_jump();
    t_same_cycle();
    t_capacity();
    t_lru();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule